// File: doc/BRIEF.md
# SDRAM Command and Address Decoder

This block watches the command pins of a four-bank DDR SDRAM module from the controller side. On every rising clock edge it samples the select, row-strobe, column-strobe and write-enable lines, the clock-enable line, the two bank-select bits and a 13-bit address bus. From these it works out which command reached the memory. It keeps a model of the open row in every bank and reports each accepted command on registered outputs, one cycle after the edge that sampled it.

Activate opens a row. Read and write report the bank, the open row, the burst start column and whether auto-precharge was asked for. Single-bank and all-bank precharge close rows. Illegal accesses raise error pulses instead of issuing anything. The clock-enable line is tracked to flag power-down and self-refresh entry and exit, and to catch levels that did not last a full cycle. An active-low asynchronous reset clears everything. The block is meant for protocol monitoring, for bus tracing, or as the bank-state front end of a memory model.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, every output is 0 and every bank is closed.
- R2: An edge with `cs_n` high decodes nothing. No command or error pulse follows, and `bank_open` keeps its value.
- R3: With (ras_n,cas_n,we_n) the command codes are: 011 activate, 101 read, 100 write, 010 precharge. Every other code is a no-op. An accepted command gives exactly one of `act_v`, `rd_v`, `wr_v`, `pre_v`, `pre_all_v` high for the single cycle after its sampling edge. `cmd_bank`, `cmd_row`, `cmd_col` and `auto_pre` are 0 whenever they do not apply.
- R4: Activate stores `addr[12:0]` as the open row of the selected bank and echoes it on `cmd_row`. A later read or write to that bank reports the stored row on `cmd_row`.
- R5: Read and write report `cmd_col = {addr[11], addr[9:0]}`, which leaves out `addr[10]`. `auto_pre` equals `addr[10]`.
- R6: The bank number is `{ba[0], ba[1]}`, where `ba[1]` is BA1 and `ba[0]` is BA0. So ba=2'b10 gives bank 1 and ba=2'b01 gives bank 2.
- R7: A read or write to a closed bank pulses `err_no_row`. No `rd_v` or `wr_v` is issued for it.
- R8: An activate to a bank that already has an open row pulses `err_row_open`. No `act_v` is issued and the stored row is kept.
- R9: Precharge with `addr[10]`=0 closes only the selected bank and pulses `pre_v` with `cmd_bank` set. With `addr[10]`=1 it closes all banks and pulses `pre_all_v` with `cmd_bank`=0.
- R10: A read or write with `auto_pre`=1 leaves that bank closed in the same cycle the command is reported.
- R11: `pwr_down` is the inverse of the last sampled `cke`. Commands are decoded only on an edge where `cke` is high and `pwr_down` was low. The edge that leaves power-down decodes nothing.
- R12: `cke_viol` pulses for one cycle when `cke` changes level at one edge and changes again at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; low requests power-down |
| ba | input | 2 | Bank select, ba[1]=BA1, ba[0]=BA0 |
| addr | input | 13 | Row address, or column plus A10 flag |
| act_v | output | 1 | Activate issued |
| rd_v | output | 1 | Read issued |
| wr_v | output | 1 | Write issued |
| pre_v | output | 1 | Single-bank precharge issued |
| pre_all_v | output | 1 | All-bank precharge issued |
| cmd_bank | output | 2 | Bank of the reported command |
| cmd_row | output | 13 | Row opened, or row being accessed |
| cmd_col | output | 11 | Burst start column |
| auto_pre | output | 1 | Auto-precharge requested |
| err_no_row | output | 1 | Access to a closed bank |
| err_row_open | output | 1 | Activate to an already open bank |
| bank_open | output | 4 | Open flag per bank |
| pwr_down | output | 1 | Power-down or self-refresh state |
| cke_viol | output | 1 | CKE level held under one cycle |

## Verification
The bench targets the column packing around A10. A design that kept A10 in the column, or dropped A11, would report a wrong column with a stray high bit. It drives the two asymmetric bank-select codes; a plain binary mapping would swap banks 1 and 2, and later accesses would hit a closed bank. It repeats activates, lets auto-precharge close a bank before it is accessed again, and mixes single-bank with all-bank precharge; a tracker that updates late or clears the wrong bank would raise false errors or miss real ones. CKE is stepped through power-down, through the exit edge and through one-cycle glitches. A design that decodes on the exit edge, or that flags every change instead of back-to-back changes, diverges from the reference model at once.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_PREA
    } cmd_e;

endpackage

// File: rtl/sdram_pin_decode.sv
module sdram_pin_decode
    import sdram_dec_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 11,
    parameter int AP_BIT = 10
) (
    input  logic              en,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ROW_W-1:0]  addr,
    output cmd_e              cmd,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic              ap
);

    // bank number is the select pair read in reverse bit order
    for (genvar i = 0; i < BANK_W; i++) begin : g_bank_rev
        assign bank[i] = ba[BANK_W-1-i];
    end

    assign row = addr;
    assign ap  = addr[AP_BIT];
    // column skips the flag bit
    assign col = {addr[COL_W:AP_BIT+1], addr[AP_BIT-1:0]};

    always_comb begin
        cmd = CMD_NOP;
        if (en && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = addr[AP_BIT] ? CMD_PREA : CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_cke_monitor.sv
module sdram_cke_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    output logic en,
    output logic pd,
    output logic viol
);

    typedef struct packed {
        logic pd;
        logic chg;
        logic viol;
    } cke_st_t;

    cke_st_t st_d, st_q;
    logic    level_change;

    // last sampled level is ~pd_q; a change means cke equals pd_q
    assign level_change = (cke == st_q.pd);

    always_comb begin
        st_d      = st_q;
        st_d.pd   = ~cke;
        st_d.chg  = level_change;
        st_d.viol = st_q.chg && level_change;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en   = cke && !st_q.pd;
    assign pd   = st_q.pd;
    assign viol = st_q.viol;

    a_r12_viol_after_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.viol |-> (st_q.pd != $past(st_q.pd)));

endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table
    import sdram_dec_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    localparam int NB    = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic              ap,
    output logic [NB-1:0]     open_vec,
    output logic [ROW_W-1:0]  sel_row,
    output logic              issue_act,
    output logic              issue_rd,
    output logic              issue_wr,
    output logic              issue_pre,
    output logic              issue_prea,
    output logic              err_no_row,
    output logic              err_row_open
);

    typedef struct packed {
        logic [NB-1:0]            open;
        logic [NB-1:0][ROW_W-1:0] rows;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic bank_is_open;

    assign bank_is_open = tbl_q.open[bank];
    assign sel_row      = tbl_q.rows[bank];

    always_comb begin
        tbl_d        = tbl_q;
        issue_act    = 1'b0;
        issue_rd     = 1'b0;
        issue_wr     = 1'b0;
        issue_pre    = 1'b0;
        issue_prea   = 1'b0;
        err_no_row   = 1'b0;
        err_row_open = 1'b0;
        unique case (cmd)
            CMD_ACT: begin
                if (bank_is_open) begin
                    err_row_open = 1'b1;
                end else begin
                    issue_act        = 1'b1;
                    tbl_d.open[bank] = 1'b1;
                    tbl_d.rows[bank] = row;
                end
            end
            CMD_RD, CMD_WR: begin
                if (!bank_is_open) begin
                    err_no_row = 1'b1;
                end else begin
                    issue_rd = (cmd == CMD_RD);
                    issue_wr = (cmd == CMD_WR);
                    if (ap) tbl_d.open[bank] = 1'b0;
                end
            end
            CMD_PRE: begin
                issue_pre        = 1'b1;
                tbl_d.open[bank] = 1'b0;
            end
            CMD_PREA: begin
                issue_prea = 1'b1;
                tbl_d.open = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign open_vec = tbl_q.open;

    a_r7_access_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_rd || issue_wr) |-> bank_is_open);

    a_r8_act_needs_closed: assert property (@(posedge clk) disable iff (!rst_n)
        issue_act |-> !bank_is_open);

endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
    import sdram_dec_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 11,
    parameter int AP_BIT = 10,
    localparam int NB    = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              cke,
    input  logic [BANK_W-1:0] ba,
    input  logic [ROW_W-1:0]  addr,
    output logic              act_v,
    output logic              rd_v,
    output logic              wr_v,
    output logic              pre_v,
    output logic              pre_all_v,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              auto_pre,
    output logic              err_no_row,
    output logic              err_row_open,
    output logic [NB-1:0]     bank_open,
    output logic              pwr_down,
    output logic              cke_viol
);

    typedef struct packed {
        logic              act;
        logic              rd;
        logic              wr;
        logic              pre;
        logic              prea;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              ap;
        logic              e_nr;
        logic              e_ro;
    } rep_t;

    rep_t rep_d, rep_q;

    logic              dec_en;
    cmd_e              dec_cmd;
    logic [BANK_W-1:0] dec_bank;
    logic [ROW_W-1:0]  dec_row;
    logic [COL_W-1:0]  dec_col;
    logic              dec_ap;
    logic [ROW_W-1:0]  tbl_row;
    logic i_act, i_rd, i_wr, i_pre, i_prea, i_enr, i_ero;

    sdram_cke_monitor u_cke (
        .clk  (clk),
        .rst_n(rst_n),
        .cke  (cke),
        .en   (dec_en),
        .pd   (pwr_down),
        .viol (cke_viol)
    );

    sdram_pin_decode #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT)
    ) u_dec (
        .en   (dec_en),
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .ba   (ba),
        .addr (addr),
        .cmd  (dec_cmd),
        .bank (dec_bank),
        .row  (dec_row),
        .col  (dec_col),
        .ap   (dec_ap)
    );

    sdram_bank_table #(
        .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) u_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (dec_cmd),
        .bank        (dec_bank),
        .row         (dec_row),
        .ap          (dec_ap),
        .open_vec    (bank_open),
        .sel_row     (tbl_row),
        .issue_act   (i_act),
        .issue_rd    (i_rd),
        .issue_wr    (i_wr),
        .issue_pre   (i_pre),
        .issue_prea  (i_prea),
        .err_no_row  (i_enr),
        .err_row_open(i_ero)
    );

    always_comb begin
        rep_d      = '0;
        rep_d.act  = i_act;
        rep_d.rd   = i_rd;
        rep_d.wr   = i_wr;
        rep_d.pre  = i_pre;
        rep_d.prea = i_prea;
        rep_d.e_nr = i_enr;
        rep_d.e_ro = i_ero;
        if (i_act || i_rd || i_wr || i_pre) rep_d.bank = dec_bank;
        if (i_act) rep_d.row = dec_row;
        if (i_rd || i_wr) begin
            rep_d.row = tbl_row;
            rep_d.col = dec_col;
            rep_d.ap  = dec_ap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rep_q <= '0;
        else        rep_q <= rep_d;
    end

    assign act_v        = rep_q.act;
    assign rd_v         = rep_q.rd;
    assign wr_v         = rep_q.wr;
    assign pre_v        = rep_q.pre;
    assign pre_all_v    = rep_q.prea;
    assign cmd_bank     = rep_q.bank;
    assign cmd_row      = rep_q.row;
    assign cmd_col      = rep_q.col;
    assign auto_pre     = rep_q.ap;
    assign err_no_row   = rep_q.e_nr;
    assign err_row_open = rep_q.e_ro;

    a_r3_one_command: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_v, rd_v, wr_v, pre_v, pre_all_v, err_no_row, err_row_open}));

    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !(act_v || rd_v || wr_v || pre_v || pre_all_v || err_no_row || err_row_open)
                 && $stable(bank_open));

    a_r9_prea_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all_v |-> (bank_open == '0));

    a_r10_autopre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_v || wr_v) && auto_pre) |-> !bank_open[cmd_bank]);

    a_r11_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !(act_v || rd_v || wr_v || pre_v || pre_all_v || err_no_row || err_row_open));

endmodule

// File: tb/sdram_cmd_decoder_bench.sv
module sdram_cmd_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, ras_n, cas_n, we_n, cke;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic        act_v, rd_v, wr_v, pre_v, pre_all_v, auto_pre;
    logic        err_no_row, err_row_open, pwr_down, cke_viol;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_row;
    logic [10:0] cmd_col;
    logic [3:0]  bank_open;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_open [4];
    int m_row  [4];
    bit m_pd;
    bit m_chg;

    always #5 clk = ~clk;

    sdram_cmd_decoder u_sdram_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .addr(addr),
        .act_v(act_v), .rd_v(rd_v), .wr_v(wr_v), .pre_v(pre_v),
        .pre_all_v(pre_all_v), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .auto_pre(auto_pre), .err_no_row(err_no_row),
        .err_row_open(err_row_open), .bank_open(bank_open),
        .pwr_down(pwr_down), .cke_viol(cke_viol)
    );

    function automatic logic [39:0] snap();
        return {act_v, rd_v, wr_v, pre_v, pre_all_v, cmd_bank, cmd_row,
                cmd_col, auto_pre, err_no_row, err_row_open, bank_open,
                pwr_down, cke_viol};
    endfunction

    task automatic compare(input logic [39:0] exp, input string tag);
        logic [39:0] act;
        act = snap();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_open[i] = 0;
            m_row[i]  = 0;
        end
        m_pd  = 1'b0;
        m_chg = 1'b0;
    endtask

    // drive at a falling edge, predict, compare at the next falling edge
    task automatic cyc(input bit c, input bit r, input bit s, input bit w,
                       input bit k, input logic [1:0] b, input logic [12:0] a,
                       input string tag);
        bit e_act = 0, e_rd = 0, e_wr = 0, e_pre = 0, e_prea = 0, e_ap = 0;
        bit e_enr = 0, e_ero = 0, e_viol, changed, dec;
        int bk;
        logic [1:0]  e_bank = '0;
        logic [12:0] e_row  = '0;
        logic [10:0] e_col  = '0;
        logic [3:0]  e_open;
        cs_n = c; ras_n = r; cas_n = s; we_n = w; cke = k; ba = b; addr = a;
        dec     = k && !m_pd;
        changed = (k != !m_pd);
        e_viol  = m_chg && changed;
        m_chg   = changed;
        m_pd    = !k;
        bk      = (b[0] ? 2 : 0) + (b[1] ? 1 : 0);
        if (dec && !c) begin
            if (!r && s && w) begin
                if (m_open[bk] != 0) e_ero = 1;
                else begin
                    m_open[bk] = 1; m_row[bk] = a;
                    e_act = 1; e_bank = 2'(bk); e_row = a;
                end
            end else if (r && !s) begin
                if (m_open[bk] == 0) e_enr = 1;
                else begin
                    e_rd = w; e_wr = !w; e_bank = 2'(bk);
                    e_row = 13'(m_row[bk]);
                    e_col = 11'((a[11] ? 1024 : 0) + (a % 1024));
                    e_ap  = a[10];
                    if (a[10]) m_open[bk] = 0;
                end
            end else if (!r && s && !w) begin
                if (a[10]) begin
                    e_prea = 1;
                    for (int i = 0; i < 4; i++) m_open[i] = 0;
                end else begin
                    e_pre = 1; e_bank = 2'(bk); m_open[bk] = 0;
                end
            end
        end
        for (int i = 0; i < 4; i++) e_open[i] = (m_open[i] != 0);
        @(negedge clk);
        compare({e_act, e_rd, e_wr, e_pre, e_prea, e_bank, e_row, e_col,
                 e_ap, e_enr, e_ero, e_open, m_pd, e_viol}, tag);
    endtask

    task automatic nop(input string tag);
        cyc(0, 1, 1, 1, 1, 2'b00, 13'h0, tag);
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        rst_n = 1'b0;
        cs_n = 0; ras_n = 1; cas_n = 1; we_n = 1; cke = 1; ba = 0; addr = 0;
        model_reset();
        repeat (3) @(negedge clk);
        compare(40'h0, "R1 reset outputs");
        rst_n = 1'b1;
        nop("R3 idle nop");

        // R6: ba=01 is bank 2, ba=10 is bank 1
        cyc(0, 0, 1, 1, 1, 2'b01, 13'h1ABC, "R6 act bank2 / R4 row");
        cyc(0, 0, 1, 1, 1, 2'b10, 13'h0123, "R6 act bank1");
        // R5: A10 low, A11 high, low bits pattern
        cyc(0, 1, 0, 1, 1, 2'b01, 13'h0A55, "R5 read col skips A10");
        cyc(0, 1, 0, 0, 1, 2'b10, 13'h03FF, "R5 write col low bits");
        // R10: write with auto-precharge closes bank 2
        cyc(0, 1, 0, 0, 1, 2'b01, 13'h1C01, "R10 write autopre");
        // R7: read now hits closed bank 2
        cyc(0, 1, 0, 1, 1, 2'b01, 13'h0005, "R7 read closed bank");
        // R8: second activate to open bank 1 keeps its row
        cyc(0, 0, 1, 1, 1, 2'b10, 13'h1FFF, "R8 act on open bank");
        cyc(0, 1, 0, 1, 1, 2'b10, 13'h0000, "R8 row kept");
        // R3: other codes are no-ops
        cyc(0, 0, 0, 1, 1, 2'b00, 13'h0000, "R3 code 001 nop");
        cyc(0, 1, 1, 0, 1, 2'b00, 13'h0000, "R3 code 110 nop");
        cyc(0, 0, 0, 0, 1, 2'b00, 13'h0400, "R3 code 000 nop");
        // R9 single then all
        cyc(0, 0, 1, 1, 1, 2'b00, 13'h0777, "R9 act bank0");
        cyc(0, 0, 1, 1, 1, 2'b11, 13'h0888, "R9 act bank3");
        cyc(0, 0, 1, 0, 1, 2'b10, 13'h0000, "R9 precharge bank1");
        cyc(0, 0, 1, 0, 1, 2'b00, 13'h0400, "R9 precharge all");
        // R2: deselected activate ignored
        cyc(1, 0, 1, 1, 1, 2'b00, 13'h0042, "R2 deselect act");
        cyc(1, 1, 0, 1, 1, 2'b00, 13'h0042, "R2 deselect read");
        cyc(0, 0, 1, 1, 1, 2'b11, 13'h0042, "R2 act after deselect");
        // R11 power-down with commands offered
        cyc(0, 1, 1, 1, 0, 2'b00, 13'h0, "R11 enter pd");
        cyc(0, 1, 1, 1, 0, 2'b00, 13'h0, "R11 hold pd");
        cyc(0, 0, 1, 0, 0, 2'b11, 13'h0000, "R11 pre ignored in pd");
        cyc(0, 0, 1, 0, 1, 2'b11, 13'h0000, "R11 exit edge ignored");
        cyc(0, 1, 0, 1, 1, 2'b11, 13'h0000, "R11 read after exit");
        // R12: one-cycle glitches
        cyc(0, 1, 1, 1, 0, 2'b00, 13'h0, "R12 cke drop");
        cyc(0, 1, 1, 1, 1, 2'b00, 13'h0, "R12 cke back viol");
        cyc(0, 1, 1, 1, 1, 2'b00, 13'h0, "R12 stable");
        cyc(0, 1, 1, 1, 1, 2'b00, 13'h0, "R12 stable again");

        // mixed traffic against the model
        for (int n = 0; n < 400; n++) begin
            bit [2:0] code = 3'($urandom_range(0, 7));
            cyc(($urandom_range(0, 5) == 0), code[2], code[1], code[0],
                ($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)),
                13'($urandom_range(0, 8191)), "R3 mixed traffic");
        end

        // R1: reset mid-run clears open banks
        cyc(0, 0, 1, 1, 1, 2'b00, 13'h0011, "R1 pre-reset act");
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        compare(40'h0, "R1 mid-run reset");
        rst_n = 1'b1;
        cyc(0, 1, 0, 1, 1, 2'b00, 13'h0000, "R1 bank closed after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule